// File: doc/BRIEF.md
# Transmit Descriptor Next-Address Sequencer

This block sits beside a transmit DMA engine that walks a list of descriptors held in memory. When the engine is done with the current descriptor, it raises a one-cycle advance request. It presents the control and address fields of that descriptor at the same time. The block then computes where the next descriptor lives.

There are three cases:
- An end-of-ring marker sends the engine back to the list base.
- A chained marker turns the descriptor's second address word into a pointer to the next descriptor.
- Without either marker, the list is treated as contiguous, with a fixed stride.

The block reports whether the second address word still describes a second data buffer. It also qualifies the descriptor's timestamp request and timestamp-captured status by the segment position of the descriptor. All results are registered. They are announced with a valid pulse one cycle after the request, and they hold until the next request.

Top module: `txd_next_seq`

## Requirements
- R1: With the end-of-ring input set and the chained input clear, the next address is the list base address.
- R2: With the chained input set and the end-of-ring input clear, the next address is the second address word.
- R3: When end-of-ring and chained are both set, end-of-ring wins and the next address is the list base address.
- R4: With both markers clear, the next address is the current address plus 16, modulo 2^32.
- R5: When chained is set, buffer-2 valid is 0 whatever the 13-bit buffer-2 size. When chained is clear, buffer-2 valid is 1 exactly when that size is nonzero.
- R6: The timestamp-enable output equals the timestamp request ANDed with the first-segment bit.
- R7: The timestamp-status-valid output equals the timestamp-captured input ANDed with the last-segment bit.
- R8: `next_valid` is high for exactly the one cycle after each cycle in which `advance` is high, and is low otherwise.
- R9: The two lowest bits of `next_addr` are always 0, whatever the low bits of the chosen source address.
- R10: While `advance` is low, all result outputs keep their values, and input changes have no effect on them.
- R11: After a synchronous active-low reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| advance | input | 1 | One-cycle request: the current descriptor is finished |
| base_addr | input | 32 | Start address of the descriptor list |
| cur_addr | input | 32 | Address of the current descriptor |
| end_ring | input | 1 | Current descriptor is the last of the ring |
| chained | input | 1 | Second address word points to the next descriptor |
| addr_word2 | input | 32 | Second address word of the descriptor |
| buf2_size | input | 13 | Buffer-2 byte count from the descriptor |
| first_seg | input | 1 | Descriptor holds the first segment of a frame |
| last_seg | input | 1 | Descriptor holds the last segment of a frame |
| ts_req | input | 1 | Descriptor asks for a transmit timestamp |
| ts_captured | input | 1 | Timestamp-captured status from the descriptor |
| next_valid | output | 1 | Pulse: results below were just updated |
| next_addr | output | 32 | Address of the next descriptor, word aligned |
| buf2_valid | output | 1 | Second address word is a usable second buffer |
| ts_enable | output | 1 | Qualified timestamp request |
| ts_status_valid | output | 1 | Qualified timestamp-captured status |

## Verification
The hardest situations to reach are the combined ones:
- both markers set while the buffer-2 size is nonzero, and a misaligned second word differs from the base, so a wrong precedence shows on `next_addr` and `buf2_valid` together;
- a current address near the top of the address space, where the 16-byte stride wraps.

Directed requests place each of these, including misaligned base and pointer words and a size of exactly zero. Random requests then draw the markers and segment bits with a bias toward both markers being set. Between requests the inputs are scrambled while `advance` stays low, so the hold behaviour is observed at the outputs.

// File: rtl/txd_pkg.sv
// Shared types for the transmit descriptor next-address sequencer.
// Assumes byte addresses of ADDR_W bits and a 13-bit buffer-2 size field.
package txd_pkg;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 13;

    // Which source produced the next descriptor address
    typedef enum logic [1:0] {
        SRC_STRIDE = 2'd0,
        SRC_CHAIN  = 2'd1,
        SRC_RING   = 2'd2
    } next_src_e;

    // Registered result bundle
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              buf2_ok;
        logic              ts_en;
        logic              ts_ok;
    } next_res_t;
endpackage

// File: rtl/txd_addr_sel.sv
// Next-address selection.
// Chooses ring base, chained pointer or contiguous stride with fixed precedence
// (end-of-ring over chained), forces word alignment and derives buffer-2 validity.
// Assumes: purely combinational, inputs stable while sampled.
module txd_addr_sel #(
    parameter int AW         = 32,
    parameter int SW         = 13,
    parameter int STRIDE     = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] addr_word2,
    input  logic [SW-1:0] buf2_size,
    input  logic          end_ring,
    input  logic          chained,
    output logic [AW-1:0] addr_out,
    output logic          buf2_ok,
    output txd_pkg::next_src_e src
);
    import txd_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(STRIDE);

    logic [AW-1:0] raw_addr;
    logic [AW-1:0] step_addr;

    // Contiguous successor, wrapping at the top of the address space
    always_comb step_addr = cur_addr + STEP;

    // Source select with end-of-ring taking precedence over chaining
    always_comb begin
        if (end_ring)     src = SRC_RING;
        else if (chained) src = SRC_CHAIN;
        else              src = SRC_STRIDE;
    end

    // Multiplex the chosen source address
    always_comb begin
        case (src)
            SRC_RING:  raw_addr = base_addr;
            SRC_CHAIN: raw_addr = addr_word2;
            default:   raw_addr = step_addr;
        endcase
    end

    // Word alignment: clear low bits, pass the rest
    genvar gi;
    generate
        for (gi = 0; gi < AW; gi++) begin : g_align
            if (gi < ALIGN_BITS) begin : g_zero
                assign addr_out[gi] = 1'b0;
            end else begin : g_pass
                assign addr_out[gi] = raw_addr[gi];
            end
        end
    endgenerate

    // Buffer 2 exists only when the word is not a chain pointer and has bytes
    always_comb buf2_ok = !chained && (buf2_size != '0);

    // R3: with both markers set, the ring source must be chosen
    always_comb begin
        if (end_ring && chained)
            a_r3_ring_wins: assert (src == SRC_RING);
    end
endmodule

// File: rtl/txd_ts_qual.sv
// Timestamp qualifier.
// Honours the timestamp request only on a first segment and the captured
// status only on a last segment. Assumes: purely combinational.
module txd_ts_qual (
    input  logic first_seg,
    input  logic last_seg,
    input  logic ts_req,
    input  logic ts_captured,
    output logic ts_en,
    output logic ts_ok
);
    // Gate the request by first-segment position
    always_comb ts_en = ts_req & first_seg;

    // Gate the captured status by last-segment position
    always_comb ts_ok = ts_captured & last_seg;
endmodule

// File: rtl/txd_out_reg.sv
// Result register.
// Captures the result bundle on an advance request, holds it otherwise, and
// raises a one-cycle valid pulse. Assumes a synchronous active-low reset.
module txd_out_reg #(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  txd_pkg::next_res_t  d,
    output txd_pkg::next_res_t  q,
    output logic                pulse
);
    // Load on request, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // One-cycle valid pulse following each request
    always_ff @(posedge clk) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= load;
    end

    // R10: without a request, the stored bundle stays put
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

    // The width parameter must agree with the package
    initial a_width_match: assert (AW == txd_pkg::ADDR_W);
endmodule

// File: rtl/txd_next_seq.sv
// Transmit descriptor next-address sequencer (top).
// On each advance request, computes the next descriptor address, buffer-2
// validity and qualified timestamp bits, and registers them with a valid pulse
// one cycle later. Assumes requests are single-cycle and inputs are valid with
// them; a synchronous active-low reset.
module txd_next_seq #(
    parameter int AW         = txd_pkg::ADDR_W,
    parameter int SW         = txd_pkg::SIZE_W,
    parameter int STRIDE     = 16,
    parameter int ALIGN_BITS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] cur_addr,
    input  logic          end_ring,
    input  logic          chained,
    input  logic [AW-1:0] addr_word2,
    input  logic [SW-1:0] buf2_size,
    input  logic          first_seg,
    input  logic          last_seg,
    input  logic          ts_req,
    input  logic          ts_captured,
    output logic          next_valid,
    output logic [AW-1:0] next_addr,
    output logic          buf2_valid,
    output logic          ts_enable,
    output logic          ts_status_valid
);
    import txd_pkg::*;

    localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << ALIGN_BITS) - 1);

    logic [AW-1:0] sel_addr;
    logic          sel_buf2;
    next_src_e     sel_src;
    logic          q_ts_en;
    logic          q_ts_ok;
    next_res_t     d_res;
    next_res_t     q_res;

    txd_addr_sel #(
        .AW(AW), .SW(SW), .STRIDE(STRIDE), .ALIGN_BITS(ALIGN_BITS)
    ) u_sel (
        .base_addr (base_addr),
        .cur_addr  (cur_addr),
        .addr_word2(addr_word2),
        .buf2_size (buf2_size),
        .end_ring  (end_ring),
        .chained   (chained),
        .addr_out  (sel_addr),
        .buf2_ok   (sel_buf2),
        .src       (sel_src)
    );

    txd_ts_qual u_ts (
        .first_seg  (first_seg),
        .last_seg   (last_seg),
        .ts_req     (ts_req),
        .ts_captured(ts_captured),
        .ts_en      (q_ts_en),
        .ts_ok      (q_ts_ok)
    );

    // Pack the combinational results for the register stage
    always_comb begin
        d_res.addr    = sel_addr;
        d_res.buf2_ok = sel_buf2;
        d_res.ts_en   = q_ts_en;
        d_res.ts_ok   = q_ts_ok;
    end

    txd_out_reg #(.AW(AW)) u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .load (advance),
        .d    (d_res),
        .q    (q_res),
        .pulse(next_valid)
    );

    // Drive the result ports from the register bundle
    always_comb begin
        next_addr       = q_res.addr;
        buf2_valid      = q_res.buf2_ok;
        ts_enable       = q_res.ts_en;
        ts_status_valid = q_res.ts_ok;
    end

    // R1: ring marker returns to the base address
    a_r1_ring_base: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && end_ring) |=> next_addr == ($past(base_addr) & ALIGN_MASK));

    // R2: chain marker alone follows the second word
    a_r2_chain_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && chained && !end_ring) |=> next_addr == ($past(addr_word2) & ALIGN_MASK));

    // R4: no marker steps by the stride
    a_r4_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !chained && !end_ring) |=>
            next_addr == (($past(cur_addr) + AW'(STRIDE)) & ALIGN_MASK));

    // R5: chaining removes buffer 2
    a_r5_no_buf2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && chained) |=> !buf2_valid);

    // R6: timestamp request without first segment is dropped
    a_r6_ts_first: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !first_seg) |=> !ts_enable);

    // R7: captured status without last segment is dropped
    a_r7_ts_last: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !last_seg) |=> !ts_status_valid);

    // R8: valid pulse follows each request and only then
    a_r8_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> next_valid);
    a_r8_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> !next_valid);

    // R9: presented address is word aligned
    a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        next_valid |-> next_addr[1:0] == 2'b00);
endmodule

// File: tb/sim_txd_next_seq.sv
module sim_txd_next_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] base_addr = '0, cur_addr = '0, addr_word2 = '0;
    logic        end_ring = 1'b0, chained = 1'b0;
    logic [12:0] buf2_size = '0;
    logic        first_seg = 1'b0, last_seg = 1'b0, ts_req = 1'b0, ts_captured = 1'b0;
    logic        next_valid, buf2_valid, ts_enable, ts_status_valid;
    logic [31:0] next_addr;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    txd_next_seq u0 (
        .clk(clk), .rst_n(rst_n), .advance(advance), .base_addr(base_addr),
        .cur_addr(cur_addr), .end_ring(end_ring), .chained(chained),
        .addr_word2(addr_word2), .buf2_size(buf2_size), .first_seg(first_seg),
        .last_seg(last_seg), .ts_req(ts_req), .ts_captured(ts_captured),
        .next_valid(next_valid), .next_addr(next_addr), .buf2_valid(buf2_valid),
        .ts_enable(ts_enable), .ts_status_valid(ts_status_valid)
    );

    function automatic logic [31:0] exp_addr(input logic er, input logic ch,
                                             input logic [31:0] b, input logic [31:0] c,
                                             input logic [31:0] w2);
        logic [31:0] a;
        if (er)      a = b;
        else if (ch) a = w2;
        else         a = c + 32'd16;
        return a & 32'hFFFF_FFFC;
    endfunction

    function automatic logic exp_buf2(input logic ch, input logic [12:0] sz);
        return !ch && (sz != 13'd0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic scramble();
        base_addr   = $urandom; cur_addr = $urandom; addr_word2 = $urandom;
        buf2_size   = 13'($urandom); end_ring = 1'($urandom); chained = 1'($urandom);
        first_seg   = 1'($urandom); last_seg = 1'($urandom);
        ts_req      = 1'($urandom); ts_captured = 1'($urandom);
    endtask

    // One request with the given fields, then checks of results and hold
    task automatic request(input logic [31:0] b, input logic [31:0] c, input logic [31:0] w2,
                           input logic er, input logic ch, input logic [12:0] sz,
                           input logic fs, input logic ls, input logic tr, input logic tc);
        logic [31:0] ea;
        logic eb, ete, ets;
        @(negedge clk);
        base_addr = b; cur_addr = c; addr_word2 = w2; end_ring = er; chained = ch;
        buf2_size = sz; first_seg = fs; last_seg = ls; ts_req = tr; ts_captured = tc;
        advance = 1'b1;
        ea = exp_addr(er, ch, b, c, w2); eb = exp_buf2(ch, sz);
        ete = tr & fs; ets = tc & ls;
        @(negedge clk);
        advance = 1'b0;
        check(er ? "R1/R3 addr" : (ch ? "R2 addr" : "R4 addr"), next_addr, ea);
        check("R9 align", {30'd0, next_addr[1:0]}, 32'd0);
        check("R5 buf2", {31'd0, buf2_valid}, {31'd0, eb});
        check("R6 ts_enable", {31'd0, ts_enable}, {31'd0, ete});
        check("R7 ts_status", {31'd0, ts_status_valid}, {31'd0, ets});
        check("R8 pulse high", {31'd0, next_valid}, 32'd1);
        scramble();
        @(negedge clk);
        check("R8 pulse low", {31'd0, next_valid}, 32'd0);
        check("R10 hold addr", next_addr, ea);
        check("R10 hold flags", {29'd0, buf2_valid, ts_enable, ts_status_valid},
              {29'd0, eb, ete, ets});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4242));
        scramble();
        advance = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset clears outputs even with a request held high
        check("R11 reset valid", {31'd0, next_valid}, 32'd0);
        check("R11 reset outs", {next_addr[30:0] | {28'd0, buf2_valid, ts_enable, ts_status_valid}},
              32'd0);
        check("R11 reset addr", next_addr, 32'd0);
        advance = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corner cases
        request(32'h1000_0003, 32'h2000_0000, 32'h3000_0002, 1, 0, 13'd5, 1, 1, 1, 1); // R1
        request(32'h1000_0000, 32'h2000_0000, 32'h3000_0007, 0, 1, 13'd99, 1, 0, 1, 1); // R2 R5
        request(32'h1000_0001, 32'h2000_0000, 32'h3000_0004, 1, 1, 13'h1FFF, 0, 1, 1, 1); // R3 R5
        request(32'h0, 32'hFFFF_FFF8, 32'h0, 0, 0, 13'd0, 0, 0, 1, 1); // R4 wrap, size 0
        request(32'h0, 32'h0000_1233, 32'h0, 0, 0, 13'd1, 1, 1, 0, 0); // R4 R9 misaligned
        // Back-to-back requests: R8
        @(negedge clk);
        base_addr = 32'h40; cur_addr = 32'h80; end_ring = 0; chained = 0; advance = 1'b1;
        @(negedge clk);
        cur_addr = 32'hA0;
        @(negedge clk);
        advance = 1'b0;
        check("R8 back-to-back valid", {31'd0, next_valid}, 32'd1);
        check("R4 back-to-back addr", next_addr, 32'hB0);
        // Random requests, biased toward both markers set
        for (int i = 0; i < 300; i++) begin
            logic er, ch;
            er = 1'($urandom);
            ch = 1'($urandom);
            if (($urandom % 4) == 0) begin er = 1; ch = 1; end
            request($urandom, $urandom, $urandom, er, ch, 13'($urandom),
                    1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule